// File: doc/BRIEF.md
# Programmable Word Aligner with Bit-Slip

This block sits on the receive side of a serial link, after the deserializer. It takes a parallel stream of `DATA_W`-bit words whose boundary may fall anywhere in the bit stream, and it returns words cut on a chosen boundary. The boundary is a bit offset from 0 to `DATA_W-1`. Before any other processing, an optional inversion flips every incoming bit to correct a swapped differential pair.

The boundary can be set in one of two ways. In search mode, a rising edge on the arm input starts a hunt for a programmable alignment pattern at every offset. The first hit locks the boundary, and the lock holds until the block is armed again. In slip mode, each rising edge of a slip request moves the boundary by one bit. The current offset is always visible on an output, so software that slips by hand knows the exact latency of the link.

Two further functions watch the stream. A one-cycle flag marks each word whose start carries the pattern. A sticky flag records any run of identical bits longer than `RUN_MAX`, and it stays set until software acknowledges a read of it. `PAT_W` is chosen among 7, 8, 10, 16, 20 and 32 bits and must not exceed `DATA_W`.

Top module: `wordAligner`

## Requirements
- R1: The stream is treated as one bit sequence, with bit 0 of each input word arriving first. With the boundary at offset 0, an input word appears unchanged on `dataOut` two rising edges after it is presented.
- R2: When `invertPol` is 1, every bit of the input word is inverted before alignment, pattern matching and run-length checking.
- R3: In search mode (`slipMode`=0), a rising edge on `armReq` starts a search and clears `syncOk`. At each later edge, if the pattern sits at some offset k of the window {current word, previous word} (bits k to k+PAT_W-1), the boundary becomes k, `slipCount` shows k and `syncOk` goes to 1.
- R4: Once locked, the pattern appearing at other offsets leaves `slipCount` and `syncOk` unchanged. Only a new rising edge of `armReq` restarts the search.
- R5: In slip mode (`slipMode`=1), each rising edge of `slipReq` adds one to the offset, wrapping from `DATA_W-1` to 0. A request held high for many cycles gives one step. `armReq` is ignored, and `syncOk` reads 0.
- R6: With the boundary at offset k, `dataOut` holds bits k to k+DATA_W-1 of the concatenation {newer word, older word}, where the older word is the one shown at offset 0. `slipCount` reports k.
- R7: `patDetect` is 1 for one cycle, in step with `dataOut`, when the output word begins with the pattern on the current boundary.
- R8: `rlvFlag` sets when a run of more than `RUN_MAX` identical bits is seen, including runs that span word edges; a run of exactly `RUN_MAX` does not set it. It stays set until a cycle with `rlvRead` high clears it, and a new violation in that same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | DATA_W | Deserialized word, bit 0 earliest |
| invertPol | input | 1 | Invert all received bits |
| slipMode | input | 1 | 0 selects pattern search, 1 selects bit-slip |
| armReq | input | 1 | Rising edge starts a pattern search |
| slipReq | input | 1 | Rising edge slips the boundary by one bit |
| pattern | input | PAT_W | Alignment pattern, bit 0 earliest |
| rlvRead | input | 1 | Software read strobe that clears the run-length flag |
| dataOut | output | DATA_W | Aligned word |
| patDetect | output | 1 | Pattern present on the current boundary |
| syncOk | output | 1 | Boundary locked by a search |
| slipCount | output | $clog2(DATA_W) | Current boundary offset in bits |
| rlvFlag | output | 1 | Sticky run-length violation |

## Verification
The properties assume that `slipMode` changes only between requests, so a slip step is always judged under one mode. They also assume that `invertPol` and `dataIn` are synchronous to `clk`, which the two-cycle latency property relies on. The stimulus changes every input just after a falling edge and changes `slipMode` only while `slipReq` and `armReq` are low. Pattern insertions are built from alternating filler that cannot form the pattern at any offset, so each search has exactly one candidate boundary.

// File: rtl/wordAligner_pkg.sv
package wordAligner_pkg;
  typedef enum logic [1:0] {AL_IDLE, AL_SEARCH, AL_LOCKED} alignState_t;

  typedef struct packed {
    logic capture;  // load the lowest matching offset
    logic step;     // advance the offset by one bit
  } alignCmd_t;
endpackage

// File: rtl/waRunLength.sv
module waRunLength #(
  parameter int DATA_W  = 10,
  parameter int RUN_MAX = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] bits,
  input  logic              clearReq,
  output logic              flag
);
  localparam int RCW = $clog2(RUN_MAX + 2);
  localparam logic [RCW-1:0] LIMIT = RCW'(RUN_MAX);
  localparam logic [RCW-1:0] SAT   = RCW'(RUN_MAX + 1);

  logic [RCW-1:0] runLen, runNext;
  logic           lastBit, lastNext, violation;

  // walk the word bit by bit, carrying the run across word edges
  always_comb begin
    runNext   = runLen;
    lastNext  = lastBit;
    violation = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (runNext == '0 || bits[i] != lastNext) runNext = RCW'(1);
      else if (runNext != SAT) runNext = runNext + RCW'(1);
      if (runNext > LIMIT) violation = 1'b1;
      lastNext = bits[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= '0;
      lastBit <= 1'b0;
      flag    <= 1'b0;
    end else begin
      runLen  <= runNext;
      lastBit <= lastNext;
      flag    <= (flag & ~clearReq) | violation;
    end
  end
endmodule

// File: rtl/waDatapath.sv
module waDatapath
  import wordAligner_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PAT_W  = 10,
  localparam int OFFW  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inWord,
  input  logic [PAT_W-1:0]  pattern,
  input  alignCmd_t         cmd,
  output logic              anyMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              patDetect,
  output logic [OFFW-1:0]   slipCount
);
  logic [DATA_W-1:0]   prevWord;
  logic [2*DATA_W-1:0] window;
  logic [DATA_W-1:0]   hits;
  logic [OFFW-1:0]     offset, firstHit;

  assign window = {inWord, prevWord};

  // one comparator per candidate boundary
  for (genvar k = 0; k < DATA_W; k++) begin : g_cmp
    assign hits[k] = (window[k +: PAT_W] == pattern);
  end

  // lowest offset wins
  always_comb begin
    firstHit = '0;
    for (int k = DATA_W - 1; k >= 0; k--)
      if (hits[k]) firstHit = OFFW'(k);
  end
  assign anyMatch = |hits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord  <= '0;
      offset    <= '0;
      dataOut   <= '0;
      patDetect <= 1'b0;
    end else begin
      prevWord  <= inWord;
      dataOut   <= window[offset +: DATA_W];
      patDetect <= hits[offset];
      if (cmd.capture)
        offset <= firstHit;
      else if (cmd.step)
        offset <= (offset == OFFW'(DATA_W - 1)) ? '0 : offset + OFFW'(1);
    end
  end

  assign slipCount = offset;
endmodule

// File: rtl/waControl.sv
module waControl
  import wordAligner_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      slipMode,
  input  logic      armReq,
  input  logic      slipReq,
  input  logic      anyMatch,
  output alignCmd_t cmd,
  output logic      syncOk
);
  alignState_t state;
  logic armPrev, slipPrev, armRise, slipRise;

  assign armRise  = armReq & ~armPrev;
  assign slipRise = slipReq & ~slipPrev;

  assign cmd.capture = !slipMode && !armRise && state == AL_SEARCH && anyMatch;
  assign cmd.step    = slipMode && slipRise;
  assign syncOk      = (state == AL_LOCKED) && !slipMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= AL_IDLE;
      armPrev  <= 1'b0;
      slipPrev <= 1'b0;
    end else begin
      armPrev  <= armReq;
      slipPrev <= slipReq;
      if (!slipMode && armRise) state <= AL_SEARCH;
      else if (cmd.capture)     state <= AL_LOCKED;
    end
  end
endmodule

// File: rtl/wordAligner.sv
module wordAligner
  import wordAligner_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int PAT_W   = 10,
  parameter int RUN_MAX = 5,
  localparam int OFFW   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              invertPol,
  input  logic              slipMode,
  input  logic              armReq,
  input  logic              slipReq,
  input  logic [PAT_W-1:0]  pattern,
  input  logic              rlvRead,
  output logic [DATA_W-1:0] dataOut,
  output logic              patDetect,
  output logic              syncOk,
  output logic [OFFW-1:0]   slipCount,
  output logic              rlvFlag
);
  logic [DATA_W-1:0] inWord;
  alignCmd_t         cmd;
  logic              anyMatch;

  assign inWord = dataIn ^ {DATA_W{invertPol}};

  waControl uCtrl (
    .clk(clk), .rstN(rstN), .slipMode(slipMode), .armReq(armReq),
    .slipReq(slipReq), .anyMatch(anyMatch), .cmd(cmd), .syncOk(syncOk)
  );

  waDatapath #(.DATA_W(DATA_W), .PAT_W(PAT_W)) uPath (
    .clk(clk), .rstN(rstN), .inWord(inWord), .pattern(pattern), .cmd(cmd),
    .anyMatch(anyMatch), .dataOut(dataOut), .patDetect(patDetect),
    .slipCount(slipCount)
  );

  waRunLength #(.DATA_W(DATA_W), .RUN_MAX(RUN_MAX)) uRun (
    .clk(clk), .rstN(rstN), .bits(inWord), .clearReq(rlvRead), .flag(rlvFlag)
  );
endmodule

// File: rtl/waChecker.sv
module waChecker #(
  parameter int DATA_W = 10,
  localparam int OFFW  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dataIn,
  input logic              invertPol,
  input logic              slipMode,
  input logic              armReq,
  input logic              rlvRead,
  input logic [DATA_W-1:0] dataOut,
  input logic              syncOk,
  input logic [OFFW-1:0]   slipCount,
  input logic              rlvFlag
);
  logic [1:0]      age;
  logic [OFFW-1:0] nextCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign nextCount = (slipCount == OFFW'(DATA_W - 1)) ? '0 : slipCount + OFFW'(1);

  // R1, R2: offset 0 passes the (optionally inverted) word after two edges
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $past(slipCount) == '0) |->
      dataOut == ($past(dataIn, 2) ^ {DATA_W{$past(invertPol, 2)}}));

  // R4: a held lock keeps its boundary without a new arm
  a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    (syncOk && !armReq) |=> $stable(slipCount));

  // R5: in slip mode the offset moves by at most one bit per cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    slipMode |=> (slipCount == $past(slipCount) || slipCount == $past(nextCount)));

  // R6: the reported offset stays inside the word
  a_r6_range: assert property (@(posedge clk) disable iff (!rstN)
    slipCount <= OFFW'(DATA_W - 1));

  // R8: the flag holds until a read
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rlvFlag && !rlvRead) |=> rlvFlag);
endmodule

bind wordAligner waChecker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .invertPol(invertPol),
  .slipMode(slipMode), .armReq(armReq), .rlvRead(rlvRead),
  .dataOut(dataOut), .syncOk(syncOk), .slipCount(slipCount), .rlvFlag(rlvFlag)
);

// File: tb/wordAligner_test.sv
module wordAligner_test;
  localparam int W  = 10;
  localparam int PL = 10;
  localparam int RL = 5;
  localparam int OW = $clog2(W);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [W-1:0]  dataIn;
  logic          invertPol, slipMode, armReq, slipReq, rlvRead;
  logic [PL-1:0] pattern;
  logic [W-1:0]  dataOut;
  logic          patDetect, syncOk, rlvFlag;
  logic [OW-1:0] slipCount;

  wordAligner #(.DATA_W(W), .PAT_W(PL), .RUN_MAX(RL)) uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .invertPol(invertPol),
    .slipMode(slipMode), .armReq(armReq), .slipReq(slipReq), .pattern(pattern),
    .rlvRead(rlvRead), .dataOut(dataOut), .patDetect(patDetect), .syncOk(syncOk),
    .slipCount(slipCount), .rlvFlag(rlvFlag)
  );

  typedef struct {
    logic [W-1:0]  d;
    logic          det;
    logic          sy;
    logic [OW-1:0] cnt;
    logic          rlv;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [W-1:0] mPrev = '0;
  int mOff = 0, mSt = 0, mRun = 0;
  logic mLast = 0, mRlv = 0, mArmPrev = 0, mSlipPrev = 0;

  localparam logic [W-1:0] FILL = 10'h155;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the item for the edge just passed
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check({e.tag, "/R1/R6"}, "dataOut", 32'(dataOut), 32'(e.d));
      check({e.tag, "/R7"}, "patDetect", 32'(patDetect), 32'(e.det));
      check({e.tag, "/R3"}, "syncOk", 32'(syncOk), 32'(e.sy));
      check({e.tag, "/R6"}, "slipCount", 32'(slipCount), 32'(e.cnt));
      check({e.tag, "/R8"}, "rlvFlag", 32'(rlvFlag), 32'(e.rlv));
    end
  end

  // driver: apply one word, push its expected result, wait for it
  task automatic step(logic [W-1:0] din, logic pol = 0, logic mode = 0,
                      logic arm = 0, logic slip = 0, logic rd = 0, string tag = "");
    exp_t e;
    logic [W-1:0] inv;
    logic [2*W-1:0] win;
    int first;
    logic viol;
    dataIn = din; invertPol = pol; slipMode = mode;
    armReq = arm; slipReq = slip; rlvRead = rd;
    inv = din ^ {W{pol}};
    win = {inv, mPrev};
    e.d   = win[mOff +: W];
    e.det = (win[mOff +: PL] == pattern);
    first = -1;
    for (int k = W - 1; k >= 0; k--) if (win[k +: PL] == pattern) first = k;
    if (!mode && arm && !mArmPrev) mSt = 1;
    else if (!mode && mSt == 1 && first >= 0) begin mSt = 2; mOff = first; end
    if (mode && slip && !mSlipPrev) mOff = (mOff + 1) % W;
    viol = 0;
    for (int i = 0; i < W; i++) begin
      if (mRun == 0 || inv[i] != mLast) mRun = 1;
      else if (mRun < RL + 1) mRun++;
      if (mRun > RL) viol = 1;
      mLast = inv[i];
    end
    mRlv = (mRlv && !rd) || viol;
    e.cnt = OW'(mOff);
    e.sy  = (mSt == 2) && !mode;
    e.rlv = mRlv;
    e.tag = tag;
    mPrev = inv; mArmPrev = arm; mSlipPrev = slip;
    sbq.push_back(e);
    @(negedge clk); #1;
  endtask

  // two words carrying the pattern at bit offset k of {second, first}
  function automatic logic [2*W-1:0] withPat(int k);
    logic [2*W-1:0] v;
    v = {FILL, FILL};
    for (int i = 0; i < PL; i++) v[k + i] = pattern[i];
    return v;
  endfunction

  initial begin
    logic [2*W-1:0] v;
    rstN = 0; dataIn = '0; invertPol = 0; slipMode = 0;
    armReq = 0; slipReq = 0; rlvRead = 0; pattern = 10'h0FA;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", "reset dataOut", 32'(dataOut), 0);
    check("R3", "reset syncOk", 32'(syncOk), 0);
    check("R6", "reset slipCount", 32'(slipCount), 0);
    check("R8", "reset rlvFlag", 32'(rlvFlag), 0);
    check("R7", "reset patDetect", 32'(patDetect), 0);
    rstN = 1;

    // R1: pass-through at offset 0
    step(10'h155, .tag("R1"));
    step(10'h2AA, .tag("R1"));
    step(10'h133, .tag("R1"));
    check("R1", "two-edge latency", 32'(dataOut), 32'h2AA);
    step(10'h0CC, .tag("R1"));
    check("R1", "next word", 32'(dataOut), 32'h133);

    // R2: polarity inversion
    step(10'h155, .pol(1), .tag("R2"));
    step(10'h2AA, .pol(1), .tag("R2"));
    check("R2", "inverted word", 32'(dataOut), 32'h2AA);
    step(FILL, .tag("R2"));

    // R3: arm and find the pattern at offset 3
    step(FILL, .arm(1), .tag("R3"));
    check("R3", "syncOk after arm", 32'(syncOk), 0);
    step(FILL, .tag("R3"));
    v = withPat(3);
    step(v[W-1:0], .tag("R3"));
    step(v[2*W-1:W], .tag("R3"));
    check("R3", "slipCount locked", 32'(slipCount), 3);
    check("R3", "syncOk locked", 32'(syncOk), 1);
    step(FILL, .tag("R3"));

    // R4: pattern at another offset is ignored while locked
    v = withPat(6);
    step(v[W-1:0], .tag("R4"));
    step(v[2*W-1:W], .tag("R4"));
    check("R4", "slipCount held", 32'(slipCount), 3);
    check("R4", "syncOk held", 32'(syncOk), 1);
    step(FILL, .arm(1), .tag("R4"));
    check("R4", "syncOk cleared by re-arm", 32'(syncOk), 0);
    step(FILL, .tag("R4"));
    step(v[W-1:0], .tag("R4"));
    step(v[2*W-1:W], .tag("R4"));
    check("R4", "slipCount re-locked", 32'(slipCount), 6);
    check("R4", "syncOk re-locked", 32'(syncOk), 1);

    // R7: pattern on the locked boundary
    step(FILL, .tag("R7"));
    step(v[W-1:0], .tag("R7"));
    step(v[2*W-1:W], .tag("R7"));
    check("R7", "patDetect pulse", 32'(patDetect), 1);
    step(FILL, .tag("R7"));
    check("R7", "patDetect drops", 32'(patDetect), 0);

    // R5: slip mode, held request gives one step, wrap, arm ignored
    step(FILL, .mode(1), .tag("R5"));
    check("R5", "syncOk low in slip mode", 32'(syncOk), 0);
    for (int i = 0; i < 4; i++) step(FILL, .mode(1), .slip(1), .tag("R5"));
    check("R5", "held request one step", 32'(slipCount), 7);
    for (int i = 0; i < 3; i++) begin
      step(FILL, .mode(1), .slip(0), .tag("R5"));
      step(FILL, .mode(1), .slip(1), .tag("R5"));
    end
    check("R5", "wrap to zero", 32'(slipCount), 0);
    step(FILL, .mode(1), .arm(1), .tag("R5"));
    step(FILL, .mode(1), .tag("R5"));
    check("R5", "arm ignored", 32'(slipCount), 0);
    check("R5", "arm ignored sync", 32'(syncOk), 0);

    // R6: aligned word at offset 2
    step(FILL, .mode(1), .slip(1), .tag("R6"));
    step(FILL, .mode(1), .tag("R6"));
    step(FILL, .mode(1), .slip(1), .tag("R6"));
    step(FILL, .mode(1), .tag("R6"));
    check("R6", "slipCount two", 32'(slipCount), 2);
    step(10'h3C3, .mode(1), .tag("R6"));
    step(10'h0F0, .mode(1), .tag("R6"));
    check("R6", "word at offset 2", 32'(dataOut), 32'(W'({10'h0F0, 10'h3C3} >> 2)));

    // R8: run-length flag
    step(10'h2AA, .mode(1), .rd(1), .tag("R8"));
    step(10'h2AA, .mode(1), .rd(1), .tag("R8"));
    check("R8", "cleared by read", 32'(rlvFlag), 0);
    step(10'h3E0, .mode(1), .tag("R8"));
    step(10'h2AA, .mode(1), .tag("R8"));
    check("R8", "run of exactly limit", 32'(rlvFlag), 0);
    step(10'h3E0, .mode(1), .tag("R8"));
    step(10'h155, .mode(1), .tag("R8"));
    check("R8", "run across words", 32'(rlvFlag), 1);
    step(10'h155, .mode(1), .tag("R8"));
    check("R8", "sticky", 32'(rlvFlag), 1);
    step(10'h2AA, .mode(1), .rd(1), .tag("R8"));
    check("R8", "clear on read", 32'(rlvFlag), 0);
    step(10'h3FF, .mode(1), .rd(1), .tag("R8"));
    check("R8", "set wins over read", 32'(rlvFlag), 1);
    step(10'h2AA, .mode(1), .tag("R8"));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule